// File: doc/BRIEF.md
# Multi-Lane Self-Test Pattern Generator

This block drives the transmit side of a serial link of up to 16 lanes during built-in self-test. Once the self-test start control is high, or compliance mode has been entered, every lane carries the four-clock symbol train 1,1,0,0. A per-lane inversion mask complements chosen lanes. With a sweep enable set, the mask walks around the lanes, so that every lane in turn receives the complemented pattern.

A second mask does the same job for the receive lanes. It produces a corrected copy of the incoming data. A loopback mode copies one half of the incoming lanes onto both halves of the outgoing lanes. This mode takes priority over the pattern, and the transmit mask is still applied to the copied data.

Top module: `lane_pattern_gen`

## Requirements
- R1: After reset, with loopback off and either the start input or compliance mode active, every transmit lane follows the repeating sequence 1,1,0,0. The first clock after reset is the first 1, and the phase advances once per clock. If neither is active, the unmasked lanes are 0.
- R2: A compliance request is accepted only while the start input is high. A request held while start is low and compliance mode is inactive leaves the outputs at their idle value.
- R3: Once compliance mode is active, it stays active while the request is held, even if start falls. It ends in the clock after the request drops.
- R4: A 1 in bit n of the active transmit mask complements transmit lane n.
- R5: While sweeping, the active mask rotates left by one lane at the end of every 4-clock pattern period, and bit 15 wraps to bit 0. At reset release the mask equals the programmed value.
- R6: While sweeping is off, the active mask follows the programmed mask one clock later and does not move.
- R7: The receive mask has its own sweep enable. The corrected receive output is the incoming lanes XOR the receive mask. The global sweep enable rotates both masks, and the transmit sweep enable leaves the receive mask still.
- R8: In loopback, loop_upper=0 copies incoming lanes 7:0 onto both halves of the transmit lanes, and loop_upper=1 copies incoming lanes 15:8. The transmit mask is XORed on top.
- R9: Loopback overrides the pattern, including while compliance mode is active.
- R10: Synchronous reset sets the pattern phase to the first symbol, reloads both masks from their programmed values, and clears compliance mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bist_start | input | 1 | Self-test start; enables the pattern |
| cmm_req | input | 1 | Compliance mode request |
| loop_en | input | 1 | Loopback mode enable |
| loop_upper | input | 1 | Loopback half select: 0 lower, 1 upper |
| tx_mask_cfg | input | LANES | Programmed transmit inversion mask |
| rx_mask_cfg | input | LANES | Programmed receive inversion mask |
| tx_sweep_en | input | 1 | Sweep enable for the transmit mask |
| rx_sweep_en | input | 1 | Sweep enable for the receive mask |
| glob_sweep_en | input | 1 | Sweep enable for both masks |
| rx_lanes | input | LANES | Incoming lane bits |
| tx_lanes | output | LANES | Outgoing lane bits |
| rx_lanes_fix | output | LANES | Incoming lanes after receive inversion |

## Verification
The assertions assume that reset is held for at least one clock before any check is relied on. They also assume that the controls change only between clock edges, so that every registered decision sees one settled set of control inputs. The stimulus asserts reset before each sweep or pattern-phase scenario. It drives all controls on the falling edge and samples outputs on the next falling edge, after the registered phase, masks and compliance flag have settled.

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen #(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bist_start,
  input  logic             cmm_req,
  input  logic             loop_en,
  input  logic             loop_upper,
  input  logic [LANES-1:0] tx_mask_cfg,
  input  logic [LANES-1:0] rx_mask_cfg,
  input  logic             tx_sweep_en,
  input  logic             rx_sweep_en,
  input  logic             glob_sweep_en,
  input  logic [LANES-1:0] rx_lanes,
  output logic [LANES-1:0] tx_lanes,
  output logic [LANES-1:0] rx_lanes_fix
);
  localparam int HALF = LANES / 2;
  localparam int PW   = 2;

  logic [PW-1:0]    phase;
  logic             cmm_act;
  logic [LANES-1:0] tx_mask_q, rx_mask_q;
  logic [HALF-1:0]  loop_half;
  logic [LANES-1:0] base;
  logic             period_end, tx_rot, rx_rot, pat_bit;

  assign period_end = (phase == {PW{1'b1}});
  assign tx_rot     = (tx_sweep_en | glob_sweep_en) & period_end;
  assign rx_rot     = (rx_sweep_en | glob_sweep_en) & period_end;
  assign pat_bit    = ~phase[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      cmm_act   <= 1'b0;
      tx_mask_q <= tx_mask_cfg;
      rx_mask_q <= rx_mask_cfg;
    end else begin
      phase   <= phase + 1'b1;
      cmm_act <= cmm_req & (cmm_act | bist_start);
      if (!(tx_sweep_en | glob_sweep_en)) tx_mask_q <= tx_mask_cfg;
      else if (tx_rot) tx_mask_q <= {tx_mask_q[LANES-2:0], tx_mask_q[LANES-1]};
      if (!(rx_sweep_en | glob_sweep_en)) rx_mask_q <= rx_mask_cfg;
      else if (rx_rot) rx_mask_q <= {rx_mask_q[LANES-2:0], rx_mask_q[LANES-1]};
    end
  end

  assign loop_half = loop_upper ? rx_lanes[LANES-1:HALF] : rx_lanes[HALF-1:0];

  always_comb begin
    if (loop_en)                  base = {loop_half, loop_half};
    else if (cmm_act | bist_start) base = {LANES{pat_bit}};
    else                          base = '0;
  end

  assign tx_lanes     = base ^ tx_mask_q;
  assign rx_lanes_fix = rx_lanes ^ rx_mask_q;
endmodule

// File: rtl/lane_pattern_gen_chk.sv
module lane_pattern_gen_chk #(
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bist_start,
  input logic             cmm_req,
  input logic             loop_en,
  input logic             tx_sweep_en,
  input logic             glob_sweep_en,
  input logic [LANES-1:0] tx_mask_cfg,
  input logic [LANES-1:0] tx_mask_q,
  input logic [LANES-1:0] tx_lanes,
  input logic [1:0]       phase,
  input logic             cmm_act
);
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> phase == $past(phase) + 2'd1); // R1
  AST_CMM_GATED: assert property (@(posedge clk) disable iff (rst) (!cmm_act && !bist_start) |=> !cmm_act); // R2
  AST_CMM_DROP: assert property (@(posedge clk) disable iff (rst) !cmm_req |=> !cmm_act); // R3
  AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst) (tx_sweep_en || glob_sweep_en) |=> $countones(tx_mask_q) == $countones($past(tx_mask_q))); // R5
  AST_STATIC_MASK: assert property (@(posedge clk) disable iff (rst) (!tx_sweep_en && !glob_sweep_en) |=> tx_mask_q == $past(tx_mask_cfg)); // R6
  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst) (!loop_en && !bist_start && !cmm_act) |-> tx_lanes == tx_mask_q); // R1
endmodule

bind lane_pattern_gen lane_pattern_gen_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/lane_pattern_gen_tb.sv
module lane_pattern_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bist_start = 0, cmm_req = 0, loop_en = 0, loop_upper = 0;
  logic [15:0] tx_mask_cfg = '0, rx_mask_cfg = '0, rx_lanes = '0;
  logic        tx_sweep_en = 0, rx_sweep_en = 0, glob_sweep_en = 0;
  logic [15:0] tx_lanes, rx_lanes_fix;
  int          checks = 0, failures = 0, cyc = 0;

  always #5 clk = ~clk;

  lane_pattern_gen u_dut (.*);

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // {rx, upper, mask, expected}
  localparam logic [63:0] VEC [6] = '{
    {16'hA5C3, 16'h0, 16'h0000, 16'hC3C3},
    {16'hA5C3, 16'h1, 16'h0000, 16'hA5A5},
    {16'h1234, 16'h0, 16'h00FF, 16'h34CB},
    {16'h1234, 16'h1, 16'hFFFF, 16'hEDED},
    {16'h0000, 16'h1, 16'h8001, 16'h8001},
    {16'hFFFF, 16'h0, 16'h0F0F, 16'hF0F0}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [15:0] rotl(logic [15:0] v, int n);
    logic [15:0] r = v;
    for (int k = 0; k < n % 16; k++) r = {r[14:0], r[15]};
    return r;
  endfunction

  function automatic logic [15:0] pat(int c);
    return ((c % 4) < 2) ? 16'hFFFF : 16'h0000;
  endfunction

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10 reset state
    rx_mask_cfg = 16'h00F0;
    do_reset();
    check("R10 idle tx after reset", tx_lanes, 16'h0000);
    check("R10 rx mask reloaded", rx_lanes_fix, 16'h00F0);

    // loopback table, R8
    loop_en = 1;
    rx_mask_cfg = 16'h0000;
    for (int i = 0; i < 6; i++) begin
      rx_lanes = VEC[i][63:48];
      loop_upper = VEC[i][32];
      tx_mask_cfg = VEC[i][31:16];
      @(negedge clk);
      check("R8 loopback vector", tx_lanes, VEC[i][15:0]);
    end
    loop_en = 0; loop_upper = 0; rx_lanes = '0; tx_mask_cfg = '0;

    // R1 pattern sequence
    bist_start = 1;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      check("R1 pattern 1100", tx_lanes, pat(cyc));
      @(negedge clk);
    end

    // R4 inversion under pattern
    tx_mask_cfg = 16'h00FF;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      check("R4 masked pattern", tx_lanes, pat(cyc) ^ 16'h00FF);
      @(negedge clk);
    end
    tx_mask_cfg = '0;
    bist_start = 0;
    do_reset();

    // R2 request without start ignored
    cmm_req = 1;
    repeat (3) @(negedge clk);
    check("R2 request ignored without start", tx_lanes, 16'h0000);
    @(negedge clk);
    check("R2 request ignored without start", tx_lanes, 16'h0000);

    // R3 entry with start, then start drops
    bist_start = 1;
    @(negedge clk);
    bist_start = 0;
    for (int i = 0; i < 4; i++) begin
      check("R3 compliance holds after start drops", tx_lanes, pat(cyc));
      @(negedge clk);
    end

    // R9 loopback overrides compliance
    loop_en = 1; loop_upper = 1; rx_lanes = 16'hABCD;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 loopback overrides compliance", tx_lanes, 16'hABAB);
    end
    loop_en = 0; rx_lanes = '0;
    @(negedge clk);
    check("R9 compliance resumes", tx_lanes, pat(cyc));

    cmm_req = 0;
    @(negedge clk);
    check("R3 compliance ends after drop", tx_lanes, 16'h0000);
    @(negedge clk);
    check("R3 compliance stays off", tx_lanes, 16'h0000);

    // R5 sweep rotation with wrap
    tx_mask_cfg = 16'h4001; tx_sweep_en = 1;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      check("R5 tx mask sweep", tx_lanes, rotl(16'h4001, cyc / 4));
      @(negedge clk);
    end

    // R6 static mask tracks config
    tx_sweep_en = 0;
    @(negedge clk);
    check("R6 static mask equals config", tx_lanes, 16'h4001);
    tx_mask_cfg = 16'h0F00;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check("R6 static mask stays", tx_lanes, 16'h0F00);
      @(negedge clk);
    end
    tx_mask_cfg = '0;

    // R7 global sweep rotates receive mask
    rx_mask_cfg = 16'h8003; glob_sweep_en = 1;
    do_reset();
    for (int i = 0; i < 12; i++) begin
      check("R7 rx mask global sweep", rx_lanes_fix, rotl(16'h8003, cyc / 4));
      @(negedge clk);
    end

    // R7 own receive sweep enable
    glob_sweep_en = 0; rx_sweep_en = 1; rx_lanes = 16'hFFFF;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      check("R7 rx mask own sweep", rx_lanes_fix, ~rotl(16'h8003, cyc / 4));
      @(negedge clk);
    end

    // R7 tx sweep leaves rx mask still
    rx_sweep_en = 0; tx_sweep_en = 1; rx_lanes = '0;
    do_reset();
    for (int i = 0; i < 10; i++) begin
      check("R7 rx mask unaffected by tx sweep", rx_lanes_fix, 16'h8003);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule